// File: doc/BRIEF.md
# CSR Read Completion Controller

This block sequences the completion of a CSR read micro-op whose result has to leave through a shared register-file write port. A read of an ordinary CSR takes its value from local storage at acceptance and is presented one cycle later. A read that goes indirectly into the external interrupt-file controller first issues a one-cycle request and then waits for that controller's read response. The result is held until the downstream write-port arbiter grants it with `out_ready`. A flush abandons the read in flight at any point.

The controller is a three-state machine. In **IDLE** it accepts work. In **WAIT** a request to the interrupt-file controller is outstanding. In **FIN** a result is held for the arbiter. The transitions are:

- **IDLE→IDLE** on flush or when nothing is valid.
- **IDLE→WAIT** on an indirect access with no permission exception.
- **IDLE→FIN** on any other valid input.
- **WAIT→IDLE** on flush, or on a response while `out_ready` is high.
- **WAIT→FIN** on a response while `out_ready` is low.
- **WAIT→WAIT** otherwise.
- **FIN→IDLE** on flush or `out_ready`.
- **FIN→FIN** otherwise.

Alongside the state machine, a combinational decoder raises a wait-for-order flag for the small set of CSRs that user-level instructions can change without a fence. A read of one of these must wait for all older instructions to complete. Reads of every other CSR, including the performance counters, may issue out of order. No CSR read ever holds back younger instructions.

Top module: `csr_rd_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1, and both `out_valid` and `aia_req_valid` are 0.
- R2: In IDLE, a valid input with `in_flush` high issues no request, produces no result, and leaves the block in IDLE.
- R3: In IDLE, a valid non-indirect input makes `out_valid` rise in the next cycle with `out_data` equal to the accepted `in_data` and `out_excp` equal to `in_excp`. This result is held until a cycle with `out_ready` high.
- R4: In IDLE, a valid indirect input with `in_excp` low drives `aia_req_valid` high in that same cycle, with `aia_req_addr` equal to `in_addr`, and moves the block to WAIT.
- R5: A valid indirect input with `in_excp` high raises no request. It completes like R3, with `out_excp` = 1.
- R6: In WAIT, a response (`aia_rsp_valid`) arriving with `out_ready` high drives `out_valid` in that same cycle with `out_data` = `aia_rsp_data`, and the block returns to IDLE.
- R7: In WAIT, a response arriving with `out_ready` low moves the block to FIN. The registered response data is then presented, stable, until `out_ready`.
- R8: A flush in WAIT returns the block to IDLE and no result is produced, even if a response arrives later.
- R9: A flush in FIN drops `out_valid` in that same cycle and returns the block to IDLE.
- R10: `ord_wait` is 1 exactly when `in_addr` is one of 0x001, 0x003, 0x008, 0x009, 0x00F, 0x100, 0x200, 0x300, 0x600, 0x744, 0x7B0. These are the float flags, float control, vector start, vector saturation, vector control, and the machine, supervisor, hypervisor, virtual-supervisor, non-maskable and debug status registers.
- R11: `ord_wait` is 0 for every other address, including the counter addresses 0xB00 and 0xC00.
- R12: `in_ready` is 0 outside IDLE. Valid inputs presented then raise no request and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Read micro-op valid |
| in_flush | input | 1 | Pipeline flush, abandons the read in flight |
| in_aia | input | 1 | Read goes indirectly to the interrupt-file controller |
| in_excp | input | 1 | Permission check has decided on an exception |
| in_addr | input | 12 | CSR address |
| in_data | input | 64 | Locally read CSR value |
| in_ready | output | 1 | Block is idle and can accept |
| aia_req_valid | output | 1 | One-cycle request to the interrupt-file controller |
| aia_req_addr | output | 12 | Address carried with the request |
| aia_rsp_valid | input | 1 | Interrupt-file read response valid |
| aia_rsp_data | input | 64 | Interrupt-file read data |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Write-port arbiter grant |
| out_data | output | 64 | Result data |
| out_excp | output | 1 | Result carries an exception |
| ord_wait | output | 1 | Read must wait for older instructions |

## Verification
The hardest case to reach is the one where the response arrives in the cycle that the arbiter is not granting. This is the WAIT→FIN path, where the data must move from the response bus into the register without a glitch. A second hard case is a flush landing in WAIT or FIN while a result is pending. The stimulus reaches these by holding `out_ready` low across the response cycle for a chosen number of cycles. It then drops `aia_rsp_data` to a different value before granting, so a design that does not register the response is exposed. Flushes are driven in each of the three states, and a late response after a WAIT flush is checked for silence.

// File: rtl/csr_rd_pkg.sv
package csr_rd_pkg;

    localparam int CSR_AW = 12;
    localparam int ORD_N  = 11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIN  = 2'd2
    } rd_state_e;

    // Addresses of CSRs whose reads must wait for all older instructions.
    function automatic logic [CSR_AW-1:0] ord_addr(input int idx);
        logic [CSR_AW-1:0] a;
        unique case (idx)
            0:       a = 12'h001;
            1:       a = 12'h003;
            2:       a = 12'h008;
            3:       a = 12'h009;
            4:       a = 12'h00F;
            5:       a = 12'h100;
            6:       a = 12'h200;
            7:       a = 12'h300;
            8:       a = 12'h600;
            9:       a = 12'h744;
            default: a = 12'h7B0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/csr_ord_decode.sv
module csr_ord_decode
    import csr_rd_pkg::*;
(
    input  logic [CSR_AW-1:0] addr,
    output logic              ord_wait
);

    logic [ORD_N-1:0] hit;

    for (genvar g = 0; g < ORD_N; g++) begin : g_match
        localparam logic [CSR_AW-1:0] MATCH = ord_addr(g);
        assign hit[g] = (addr == MATCH);
    end

    assign ord_wait = |hit;

    always_comb begin
        if (!$isunknown(addr)) begin
            assert_ord_onehot_R10: assert ($onehot0(hit));
        end
    end

endmodule

// File: rtl/csr_rd_fsm.sv
module csr_rd_fsm
    import csr_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_flush,
    input  logic in_aia,
    input  logic in_excp,
    input  logic rsp_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic aia_req_valid,
    output logic out_valid,
    output logic accept,
    output logic cap_rsp,
    output logic in_wait,
    output logic hold_fin
);

    rd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && !in_flush) begin
                    state_d = (in_aia && !in_excp) ? ST_WAIT : ST_FIN;
                end
            end
            ST_WAIT: begin
                if (in_flush) begin
                    state_d = ST_IDLE;
                end else if (rsp_valid) begin
                    state_d = out_ready ? ST_IDLE : ST_FIN;
                end
            end
            ST_FIN: begin
                if (in_flush || out_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready      = 1'b0;
        accept        = 1'b0;
        aia_req_valid = 1'b0;
        out_valid     = 1'b0;
        cap_rsp       = 1'b0;
        in_wait       = 1'b0;
        hold_fin      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready      = 1'b1;
                accept        = in_valid && !in_flush;
                aia_req_valid = in_valid && !in_flush && in_aia && !in_excp;
            end
            ST_WAIT: begin
                in_wait   = 1'b1;
                out_valid = rsp_valid && !in_flush;
                cap_rsp   = rsp_valid && !in_flush;
            end
            ST_FIN: begin
                out_valid = !in_flush;
                hold_fin  = !in_flush && !out_ready;
            end
            default: ;
        endcase
    end

    assert_idle_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid && in_flush) |=> (state_q == ST_IDLE));

    assert_req_to_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        aia_req_valid |=> (state_q == ST_WAIT));

    assert_no_req_on_excp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_excp) |-> !aia_req_valid);

    assert_rsp_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && rsp_valid && !in_flush && !out_ready) |=> (state_q == ST_FIN));

    assert_wait_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && in_flush) |=> (state_q == ST_IDLE));

    assert_fin_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN && in_flush) |-> !out_valid);

    assert_busy_no_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (!in_ready && !aia_req_valid));

endmodule

// File: rtl/csr_rd_data.sv
module csr_rd_data #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          cap_rsp,
    input  logic          in_wait,
    input  logic          hold_fin,
    input  logic [DW-1:0] in_data,
    input  logic          in_excp,
    input  logic [DW-1:0] rsp_data,
    output logic [DW-1:0] out_data,
    output logic          out_excp
);

    logic [DW-1:0] data_q;
    logic          excp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            excp_q <= 1'b0;
        end else if (accept) begin
            data_q <= in_data;
            excp_q <= in_excp;
        end else if (cap_rsp) begin
            data_q <= rsp_data;
            excp_q <= 1'b0;
        end
    end

    always_comb begin
        out_data = in_wait ? rsp_data : data_q;
        out_excp = in_wait ? 1'b0 : excp_q;
    end

    assert_fin_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_fin |=> ($stable(out_data) && $stable(out_excp)));

endmodule

// File: rtl/csr_rd_ctrl.sv
module csr_rd_ctrl
    import csr_rd_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_flush,
    input  logic              in_aia,
    input  logic              in_excp,
    input  logic [CSR_AW-1:0] in_addr,
    input  logic [DW-1:0]     in_data,
    output logic              in_ready,
    output logic              aia_req_valid,
    output logic [CSR_AW-1:0] aia_req_addr,
    input  logic              aia_rsp_valid,
    input  logic [DW-1:0]     aia_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW-1:0]     out_data,
    output logic              out_excp,
    output logic              ord_wait
);

    logic accept, cap_rsp, in_wait, hold_fin;

    csr_rd_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_flush      (in_flush),
        .in_aia        (in_aia),
        .in_excp       (in_excp),
        .rsp_valid     (aia_rsp_valid),
        .out_ready     (out_ready),
        .in_ready      (in_ready),
        .aia_req_valid (aia_req_valid),
        .out_valid     (out_valid),
        .accept        (accept),
        .cap_rsp       (cap_rsp),
        .in_wait       (in_wait),
        .hold_fin      (hold_fin)
    );

    csr_rd_data #(.DW(DW)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cap_rsp  (cap_rsp),
        .in_wait  (in_wait),
        .hold_fin (hold_fin),
        .in_data  (in_data),
        .in_excp  (in_excp),
        .rsp_data (aia_rsp_data),
        .out_data (out_data),
        .out_excp (out_excp)
    );

    csr_ord_decode u_ord (
        .addr     (in_addr),
        .ord_wait (ord_wait)
    );

    assign aia_req_addr = in_addr;

    assert_req_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        aia_req_valid |-> (aia_req_addr == in_addr && in_aia && in_valid));

    assert_out_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && !in_flush && !in_aia) |=> out_valid || in_flush);

endmodule

// File: tb/csr_rd_ctrl_tb.sv
module csr_rd_ctrl_tb;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_flush = 1'b0, in_aia = 1'b0, in_excp = 1'b0;
    logic [11:0]   in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, aia_req_valid;
    logic [11:0]   aia_req_addr;
    logic          aia_rsp_valid = 1'b0;
    logic [DW-1:0] aia_rsp_data = '0;
    logic          out_valid, out_excp, ord_wait;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          excp;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    csr_rd_ctrl #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_flush(in_flush), .in_aia(in_aia), .in_excp(in_excp),
        .in_addr(in_addr), .in_data(in_data), .in_ready(in_ready),
        .aia_req_valid(aia_req_valid), .aia_req_addr(aia_req_addr),
        .aia_rsp_valid(aia_rsp_valid), .aia_rsp_data(aia_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_excp(out_excp), .ord_wait(ord_wait)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every accepted result.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R12 unexpected result", out_data, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(out_data == e.data, "R3/R6/R7 result data", out_data, e.data);
                chk(out_excp == e.excp, "R3/R5 result excp", {63'd0, out_excp}, {63'd0, e.excp});
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drop_inputs();
        in_valid = 1'b0; in_flush = 1'b0; in_aia = 1'b0; in_excp = 1'b0;
    endtask

    task automatic local_read(input logic [11:0] a, input logic [DW-1:0] d, input logic ex, input bit aia, input int stall);
        in_valid = 1'b1; in_aia = aia; in_excp = ex; in_addr = a; in_data = d;
        #1;
        chk(in_ready == 1'b1, "R3 ready in idle", {63'd0, in_ready}, 64'd1);
        chk(aia_req_valid == 1'b0, "R5 no request", {63'd0, aia_req_valid}, 64'd0);
        exp_q.push_back('{data: d, excp: ex});
        step();
        drop_inputs();
        for (int i = 0; i < stall; i++) begin
            // R12: busy inputs must be ignored
            in_valid = 1'b1; in_aia = 1'b1; in_data = ~d;
            #1;
            chk(out_valid == 1'b1 && out_data == d, "R3 held result", out_data, d);
            chk(aia_req_valid == 1'b0 && in_ready == 1'b0, "R12 busy ignores input",
                {62'd0, aia_req_valid, in_ready}, 64'd0);
            step();
            drop_inputs();
        end
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        #1;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R3 back to idle", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic aia_read(input logic [11:0] a, input logic [DW-1:0] r, input int delay, input int stall);
        in_valid = 1'b1; in_aia = 1'b1; in_addr = a; in_data = 64'hDEAD;
        #1;
        chk(aia_req_valid == 1'b1, "R4 request pulse", {63'd0, aia_req_valid}, 64'd1);
        chk(aia_req_addr == a, "R4 request addr", {52'd0, aia_req_addr}, {52'd0, a});
        step();
        drop_inputs();
        #1;
        chk(in_ready == 1'b0 && aia_req_valid == 1'b0, "R4 in wait",
            {62'd0, in_ready, aia_req_valid}, 64'd0);
        for (int i = 0; i < delay; i++) begin
            chk(out_valid == 1'b0, "R6 no output before response", {63'd0, out_valid}, 64'd0);
            step();
        end
        aia_rsp_valid = 1'b1; aia_rsp_data = r; out_ready = (stall == 0);
        exp_q.push_back('{data: r, excp: 1'b0});
        #1;
        chk(out_valid == 1'b1 && out_data == r, "R6 same-cycle output", out_data, r);
        step();
        aia_rsp_valid = 1'b0; aia_rsp_data = ~r; out_ready = 1'b0;
        for (int i = 0; i < stall; i++) begin
            #1;
            chk(out_valid == 1'b1 && out_data == r, "R7 registered response held", out_data, r);
            step();
        end
        if (stall > 0) begin
            out_ready = 1'b1;
            step();
            out_ready = 1'b0;
        end
        #1;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R6 back to idle", {63'd0, in_ready}, 64'd1);
    endtask

    initial begin
        logic [11:0] ord_list [11];
        logic [11:0] other_list [6];
        ord_list = '{12'h001, 12'h003, 12'h008, 12'h009, 12'h00F, 12'h100,
                     12'h200, 12'h300, 12'h600, 12'h744, 12'h7B0};
        other_list = '{12'hB00, 12'hC00, 12'h002, 12'h301, 12'h7B1, 12'h5C0};

        #5;
        #1;
        chk(in_ready == 1'b1 && out_valid == 1'b0 && aia_req_valid == 1'b0, "R1 reset state",
            {61'd0, in_ready, out_valid, aia_req_valid}, 64'd4);
        step();
        rst_n = 1'b1;
        step();

        // R10 / R11 order decode
        foreach (ord_list[i]) begin
            in_addr = ord_list[i];
            #1;
            chk(ord_wait == 1'b1, "R10 ordered CSR", {63'd0, ord_wait}, 64'd1);
        end
        foreach (other_list[i]) begin
            in_addr = other_list[i];
            #1;
            chk(ord_wait == 1'b0, "R11 unordered CSR", {63'd0, ord_wait}, 64'd0);
        end

        // R2 flush in idle
        in_valid = 1'b1; in_flush = 1'b1; in_aia = 1'b1;
        #1;
        chk(aia_req_valid == 1'b0, "R2 no request on flush", {63'd0, aia_req_valid}, 64'd1 - 64'd1);
        step();
        drop_inputs();
        #1;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R2 stays idle", {63'd0, in_ready}, 64'd1);

        // R3 local reads
        local_read(12'h300, 64'h1111_2222_3333_4444, 1'b0, 1'b0, 0);
        local_read(12'hB00, 64'hA5A5_0000_FFFF_0001, 1'b1, 1'b0, 3);

        // R5 indirect with exception
        local_read(12'h150, 64'h0000_0000_0000_0BAD, 1'b1, 1'b1, 1);

        // R6 / R7 indirect reads
        aia_read(12'h151, 64'hCAFE_F00D_0000_0001, 0, 0);
        aia_read(12'h251, 64'h0123_4567_89AB_CDEF, 3, 0);
        aia_read(12'h351, 64'hFEDC_BA98_7654_3210, 1, 2);

        // R8 flush in wait, late response silent
        in_valid = 1'b1; in_aia = 1'b1; in_addr = 12'h151;
        step();
        drop_inputs();
        in_flush = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R8 no output on flush", {63'd0, out_valid}, 64'd0);
        step();
        in_flush = 1'b0;
        aia_rsp_valid = 1'b1; aia_rsp_data = 64'h77; out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R8 idle after flush, late response ignored",
            {62'd0, in_ready, out_valid}, 64'd2);
        step();
        aia_rsp_valid = 1'b0; out_ready = 1'b0;

        // R9 flush in finish
        in_valid = 1'b1; in_data = 64'h99;
        step();
        drop_inputs();
        #1;
        chk(out_valid == 1'b1, "R9 result pending", {63'd0, out_valid}, 64'd1);
        in_flush = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R9 flush drops valid", {63'd0, out_valid}, 64'd0);
        step();
        in_flush = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R9 back to idle", {63'd0, in_ready}, 64'd1);

        step();
        chk(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule